// File: doc/BRIEF.md
# Synchronous Burst SRAM Core with Flow-Through Reads

This block is the storage and control core of a synchronous static RAM with a burst interface. On every rising clock edge it takes in the address, the write data, three chip enables, two address strobes, an advance input and the write controls. From these it works out what kind of cycle follows: deselect, begin read, begin write, continue burst or suspend burst. The storage is a parameterised array that holds 36-bit words split into four 9-bit byte lanes. Read data comes straight from the array at the registered address, with no output register, so it appears in the cycle right after the capture edge.

The two strobes follow different enable rules. The processor-side strobe is ignored while the primary enable is inactive, and it can only start reads. Only the controller-side strobe can start a write. The write decode has three parts: a global write overrides the write enable and the per-lane selects.

The block does not compute the burst order. A separate burst address generator supplies the next two low address bits, and the block uses them when the burst advances. The tri-state pad sits outside the block. The core provides the read word and a drive enable. That enable is gated by an asynchronous output enable and is forced inactive while the core is deselected or in a write burst.

Top module: `sbsram_core`

## Requirements
- R1: A synchronous active-high reset puts the core in the deselected state: `dq_oe` is low in the cycle after reset, and no lane is written.
- R2: A word is 36 bits in four 9-bit lanes. Lane k occupies bits [9k+8:9k] and is controlled by the active-low select `bsel_n[k]`.
- R3: When `gw_n` is low at a write-start edge, all four lanes are written, whatever `we_n` and `bsel_n` are.
- R4: With `gw_n` high and `we_n` low, only the lanes whose select is low are written. When `we_n` is low and all selects are high, the cycle is a read.
- R5: If `adsp_n` is low, `ce1_n` is low, `ce2` is high and `ce3_n` is low, a read begins at the external address, whatever the write inputs are.
- R6: While `ce1_n` is high, a low `adsp_n` has no effect. With `adsc_n` high the cycle continues or suspends the burst; with `adsc_n` low the core is deselected.
- R7: Two cases deselect the core. First: `adsp_n` low, `ce1_n` low, and either `ce2` low or `ce3_n` high. Second: `adsp_n` high, `adsc_n` low, and any enable inactive.
- R8: With `adsp_n` high, `adsc_n` low and all enables active, a burst begins at the external address. It is a write burst if the write decode requests one, and a read burst otherwise.
- R9: If both strobes are inactive (or `adsp_n` is blocked by `ce1_n` high and `adsc_n` is high) and `adv_n` is low, the two low address bits take the value of `next_lo` and the upper bits are kept. The burst keeps its read or write type.
- R10: In the same strobe situation with `adv_n` high, the burst stays at the current address and keeps its type.
- R11: In a read cycle, `dq_o` carries the word stored at the address registered at the previous edge. A word written at one edge can be read back in the cycle after the next edge.
- R12: `dq_oe` is high only while the core is selected, in a read burst and `oe_n` is low. `oe_n` acts combinationally, without waiting for a clock edge.
- R13: Once deselected, continue and suspend cycles leave the core deselected and write nothing, even with the write inputs asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | External word address |
| next_lo | input | 2 | Next two low address bits from the burst address generator |
| adsp_n | input | 1 | Processor-side address strobe, active low |
| adsc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Depth-expansion enable, active high |
| ce3_n | input | 1 | Depth-expansion enable, active low |
| gw_n | input | 1 | Global write, active low |
| we_n | input | 1 | Lane write enable, active low |
| bsel_n | input | 4 | Per-lane write selects, active low, bit k for lane k |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_i | input | 36 | Write data from the pad |
| dq_o | output | 36 | Flow-through read data toward the pad |
| dq_oe | output | 1 | Pad drive enable |

## Verification
The bench builds the core with `ADDR_W = 4`, which gives a 16-word array. At that size the bench can first write every word through linear four-beat write bursts, then read every word back with interleaved bursts, and keep a full reference copy of the array. The same small configuration makes it practical to run all sixteen lane-select patterns and all eight chip-enable combinations under each strobe arrangement. After each of those cycles the bench reads the stored words back, so a stray write or a missed deselect shows up in the data.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [2:0] {
        CYC_IDLE,
        CYC_RD_START,
        CYC_WR_START,
        CYC_ADVANCE,
        CYC_HOLD
    } cyc_kind_t;

    typedef struct packed {
        logic             adsp_n;
        logic             adsc_n;
        logic             adv_n;
        logic             ce1_n;
        logic             ce2;
        logic             ce3_n;
        logic             gw_n;
        logic             we_n;
        logic [LANES-1:0] bsel_n;
    } strobe_t;

    // all three enables in their active state
    function automatic logic chip_enabled(strobe_t s);
        return !s.ce1_n && s.ce2 && !s.ce3_n;
    endfunction

    // lanes a write would touch; global write wins over everything else
    function automatic logic [LANES-1:0] lane_mask(strobe_t s);
        if (!s.gw_n)
            return '1;
        if (!s.we_n)
            return ~s.bsel_n;
        return '0;
    endfunction

    function automatic cyc_kind_t classify(strobe_t s);
        if (!s.adsp_n && !s.ce1_n)
            return chip_enabled(s) ? CYC_RD_START : CYC_IDLE;
        if (!s.adsc_n) begin
            if (!chip_enabled(s))
                return CYC_IDLE;
            return (lane_mask(s) != '0) ? CYC_WR_START : CYC_RD_START;
        end
        return s.adv_n ? CYC_HOLD : CYC_ADVANCE;
    endfunction

endpackage

// File: rtl/sbsram_decode.sv
module sbsram_decode
    import sbsram_pkg::*;
(
    input  strobe_t          ctl,
    output cyc_kind_t        kind,
    output logic [LANES-1:0] lanes
);

    always_comb begin
        kind  = classify(ctl);
        lanes = lane_mask(ctl);
    end

endmodule

// File: rtl/sbsram_burst_state.sv
module sbsram_burst_state
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  cyc_kind_t         kind,
    input  logic [LANES-1:0]  lanes_in,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic [1:0]        next_lo,
    input  logic [WORD_W-1:0] din,
    output logic              sel_q,
    output logic              wr_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [LANES-1:0]  lanes_q,
    output logic [WORD_W-1:0] data_q
);

    localparam int HI_W = ADDR_W - 2;

    logic [LANES-1:0] burst_lanes;

    // inside a running write burst the lane decode of this cycle applies
    assign burst_lanes = (sel_q && wr_q) ? lanes_in : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= 1'b0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            lanes_q <= '0;
            data_q  <= '0;
        end else begin
            data_q <= din;
            unique case (kind)
                CYC_IDLE: begin
                    sel_q   <= 1'b0;
                    lanes_q <= '0;
                end
                CYC_RD_START: begin
                    sel_q   <= 1'b1;
                    wr_q    <= 1'b0;
                    addr_q  <= ext_addr;
                    lanes_q <= '0;
                end
                CYC_WR_START: begin
                    sel_q   <= 1'b1;
                    wr_q    <= 1'b1;
                    addr_q  <= ext_addr;
                    lanes_q <= lanes_in;
                end
                CYC_ADVANCE: begin
                    addr_q  <= {addr_q[ADDR_W-1 -: HI_W], next_lo};
                    lanes_q <= burst_lanes;
                end
                CYC_HOLD: begin
                    lanes_q <= burst_lanes;
                end
                default: begin
                    sel_q   <= 1'b0;
                    lanes_q <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic [LANES-1:0]  wr_lanes,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_lanes[g])
                bank[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        assign rd_data[g*LANE_W +: LANE_W] = bank[rd_addr];
    end

endmodule

// File: rtl/sbsram_core.sv
module sbsram_core
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        next_lo,
    input  logic              adsp_n,
    input  logic              adsc_n,
    input  logic              adv_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              gw_n,
    input  logic              we_n,
    input  logic [LANES-1:0]  bsel_n,
    input  logic              oe_n,
    input  logic [WORD_W-1:0] dq_i,
    output logic [WORD_W-1:0] dq_o,
    output logic              dq_oe
);

    strobe_t           ctl;
    cyc_kind_t         kind;
    logic [LANES-1:0]  dec_lanes;
    logic              sel_q;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  lanes_q;
    logic [WORD_W-1:0] data_q;
    logic [WORD_W-1:0] rd_word;

    assign ctl = '{adsp_n: adsp_n, adsc_n: adsc_n, adv_n: adv_n,
                   ce1_n: ce1_n, ce2: ce2, ce3_n: ce3_n,
                   gw_n: gw_n, we_n: we_n, bsel_n: bsel_n};

    sbsram_decode u_dec (
        .ctl   (ctl),
        .kind  (kind),
        .lanes (dec_lanes)
    );

    sbsram_burst_state #(.ADDR_W(ADDR_W)) u_state (
        .clk      (clk),
        .rst      (rst),
        .kind     (kind),
        .lanes_in (dec_lanes),
        .ext_addr (addr),
        .next_lo  (next_lo),
        .din      (dq_i),
        .sel_q    (sel_q),
        .wr_q     (wr_q),
        .addr_q   (addr_q),
        .lanes_q  (lanes_q),
        .data_q   (data_q)
    );

    // write commits one edge after capture from the registered stage
    sbsram_array #(.ADDR_W(ADDR_W)) u_mem (
        .clk      (clk),
        .wr_lanes (lanes_q),
        .wr_addr  (addr_q),
        .wr_data  (data_q),
        .rd_addr  (addr_q),
        .rd_data  (rd_word)
    );

    assign dq_o  = rd_word;
    assign dq_oe = sel_q && !wr_q && !oe_n;

endmodule

// File: rtl/sbsram_core_chk.sv
module sbsram_core_chk
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              adsp_n,
    input logic              adsc_n,
    input logic              adv_n,
    input logic              ce1_n,
    input logic              ce2,
    input logic              ce3_n,
    input logic              gw_n,
    input logic              oe_n,
    input logic [1:0]        next_lo,
    input logic              dq_oe,
    input logic              sel_q,
    input logic              wr_q,
    input logic [ADDR_W-1:0] addr_q,
    input logic [LANES-1:0]  lanes_q
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!sel_q && lanes_q == '0));

    // R12
    oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (oe_n || wr_q) |-> !dq_oe);

    // R5
    adsp_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!adsp_n && !ce1_n && ce2 && !ce3_n) |=> (sel_q && !wr_q && lanes_q == '0));

    // R6
    blocked_desel_chk: assert property (@(posedge clk) disable iff (rst)
        (ce1_n && !adsc_n) |=> !sel_q);

    // R3
    global_write_chk: assert property (@(posedge clk) disable iff (rst)
        (adsp_n && !adsc_n && !ce1_n && ce2 && !ce3_n && !gw_n) |=> (wr_q && lanes_q == '1));

    // R10
    hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (adsp_n && adsc_n && adv_n) |=> ($stable(addr_q) && $stable(wr_q)));

    // R9
    advance_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (adsp_n && adsc_n && !adv_n) |=>
            (addr_q[1:0] == $past(next_lo) && addr_q[ADDR_W-1:2] == $past(addr_q[ADDR_W-1:2])));

    // R13
    stay_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!sel_q && adsc_n && (adsp_n || ce1_n)) |=> (!sel_q && lanes_q == '0));

endmodule

bind sbsram_core sbsram_core_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .adsp_n  (adsp_n),
    .adsc_n  (adsc_n),
    .adv_n   (adv_n),
    .ce1_n   (ce1_n),
    .ce2     (ce2),
    .ce3_n   (ce3_n),
    .gw_n    (gw_n),
    .oe_n    (oe_n),
    .next_lo (next_lo),
    .dq_oe   (dq_oe),
    .sel_q   (sel_q),
    .wr_q    (wr_q),
    .addr_q  (addr_q),
    .lanes_q (lanes_q)
);

// File: tb/sbsram_core_test.sv
module sbsram_core_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic [1:0]    next_lo;
    logic          adsp_n, adsc_n, adv_n, ce1_n, ce2, ce3_n, gw_n, we_n, oe_n;
    logic [3:0]    bsel_n;
    logic [35:0]   dq_i;
    logic [35:0]   dq_o;
    logic          dq_oe;

    int checks = 0;
    int errors = 0;

    // reference state, derived from the requirements
    logic [35:0]   m_mem [DEPTH];
    logic          m_sel, m_wr;
    logic [AW-1:0] m_addr;
    logic [3:0]    m_lanes;
    logic [35:0]   m_data;

    sbsram_core #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .addr(addr), .next_lo(next_lo),
        .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .gw_n(gw_n), .we_n(we_n), .bsel_n(bsel_n), .oe_n(oe_n),
        .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [35:0] pat(int a, int s);
        logic [8:0] b;
        b = 9'(a * 29 + s * 53 + 17);
        return {b, b, b, b} ^ {9'h1A5, 9'h05A, 9'h133, 9'h0C6};
    endfunction

    task automatic check(string req, logic [35:0] got, logic [35:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic quiet();
        adsp_n = 1; adsc_n = 1; adv_n = 1;
        ce1_n = 0; ce2 = 1; ce3_n = 0;
        gw_n = 1; we_n = 1; bsel_n = 4'hF;
        next_lo = 0; dq_i = '0;
    endtask

    task automatic model_edge();
        logic       en, wr_req;
        logic [3:0] lanes;
        for (int l = 0; l < 4; l++)
            if (m_lanes[l]) m_mem[m_addr][l*9 +: 9] = m_data[l*9 +: 9];
        if (rst) begin
            m_sel = 0; m_wr = 0; m_addr = '0; m_lanes = '0; m_data = '0;
        end else begin
            en     = !ce1_n && ce2 && !ce3_n;
            lanes  = !gw_n ? 4'hF : (!we_n ? ~bsel_n : 4'h0);
            wr_req = lanes != 4'h0;
            if (!adsp_n && !ce1_n) begin
                m_lanes = '0;
                if (en) begin m_sel = 1; m_wr = 0; m_addr = addr; end
                else m_sel = 0;
            end else if (!adsc_n) begin
                if (en) begin
                    m_sel = 1; m_wr = wr_req; m_addr = addr;
                    m_lanes = wr_req ? lanes : 4'h0;
                end else begin
                    m_sel = 0; m_lanes = '0;
                end
            end else begin
                if (!adv_n) m_addr[1:0] = next_lo;
                m_lanes = (m_sel && m_wr) ? lanes : 4'h0;
            end
            m_data = dq_i;
        end
    endtask

    task automatic compare(string req);
        logic exp_oe;
        exp_oe = m_sel && !m_wr && !oe_n;
        check(req, 36'(dq_oe), 36'(exp_oe));
        if (exp_oe) check(req, dq_o, m_mem[m_addr]);
    endtask

    task automatic tick(string req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        #1;
        compare(req);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_sel = 0; m_wr = 0; m_addr = '0; m_lanes = '0; m_data = '0;
        quiet();
        addr = '0; oe_n = 0; rst = 1;
        @(negedge clk);
        tick("R1");
        tick("R1");
        rst = 0;
        tick("R1");

        // fill every word: global-write bursts, linear order, varied start
        oe_n = 1;
        for (int g = 0; g < DEPTH / 4; g++) begin
            logic [1:0] lo;
            lo = 2'(g);
            quiet();
            adsc_n = 0; gw_n = 0; we_n = 1; bsel_n = 4'hF;
            addr = AW'({2'(g), lo});
            dq_i = pat(g * 4 + lo, 0);
            tick("R3");
            adsc_n = 1; adv_n = 0;
            for (int k = 1; k < 4; k++) begin
                next_lo = lo + 2'(k);
                dq_i = pat(g * 4 + next_lo, 0);
                tick("R9");
            end
        end
        quiet();
        tick("R10");

        // read back every word via ADSP with write inputs asserted, interleaved bursts
        oe_n = 0;
        for (int a = 0; a < DEPTH; a++) begin
            quiet();
            adsp_n = 0; gw_n = 0; we_n = 0; bsel_n = 4'h0;
            addr = AW'(a);
            tick("R5");
            check("R11", dq_o, pat(a, 0));
            adsp_n = 1; adv_n = 0;
            for (int k = 1; k < 4; k++) begin
                next_lo = 2'(a) ^ 2'(k);
                tick("R9");
            end
            adv_n = 1;
            tick("R10");
        end

        // all lane select patterns through ADSC with lane writes
        for (int m = 0; m < 16; m++) begin
            quiet();
            oe_n = (m == 15) ? 1'b0 : 1'b1;
            adsc_n = 0; we_n = 0; bsel_n = 4'(m);
            addr = AW'(m);
            dq_i = pat(m, 7);
            tick((m == 15) ? "R4" : "R8");
            quiet();
            oe_n = 0; adsp_n = 0; addr = AW'(m);
            tick("R2");
            tick("R11");
        end

        // chip enable combinations under each strobe arrangement
        for (int s = 0; s < 3; s++) begin
            for (int c = 0; c < 8; c++) begin
                quiet();
                oe_n = 0; adsp_n = 0; addr = AW'(5);
                tick("R5");
                adsp_n = (s == 1) ? 1'b1 : 1'b0;
                adsc_n = (s == 0) ? 1'b1 : 1'b0;
                ce1_n = c[0]; ce2 = c[1]; ce3_n = c[2];
                gw_n = 0; adv_n = 0; next_lo = 2'd1; addr = AW'(9);
                dq_i = pat(c, s + 20);
                tick((s == 0 && c[0]) ? "R6" : "R7");
                quiet();
                adv_n = 0; gw_n = 0; next_lo = 2'(c);
                dq_i = pat(c, s + 40);
                tick("R13");
                adv_n = 1;
                tick("R13");
                quiet();
                adsp_n = 0; addr = AW'(9);
                tick("R11");
                adsp_n = 1; adv_n = 0;
                for (int k = 0; k < 4; k++) begin
                    next_lo = 2'(k);
                    tick("R9");
                end
            end
        end

        // output enable acts without a clock edge
        quiet();
        oe_n = 0; adsp_n = 0; addr = AW'(3);
        tick("R12");
        for (int t = 0; t < 4; t++) begin
            oe_n = t[0];
            #2;
            compare("R12");
        end

        // write burst keeps its type: no drive even with oe_n low
        quiet();
        oe_n = 0; adsc_n = 0; gw_n = 0; addr = AW'(3);
        dq_i = pat(3, 99);
        tick("R12");
        quiet();
        oe_n = 0; adv_n = 0; next_lo = 2'd0;
        tick("R9");
        adv_n = 1;
        tick("R10");
        quiet();
        adsp_n = 0; addr = AW'(3);
        tick("R11");
        check("R3", dq_o, pat(3, 99));

        // reset in the middle of a read burst
        rst = 1;
        tick("R1");
        rst = 0;
        quiet();
        tick("R1");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule